// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a dual-ported memory array and watches the two access ports. When both ports are enabled and present the same address, it decides which of them may use the location. The port that reached the shared address in an earlier cycle keeps it. A port that arrives later sees its busy flag go low, and its write strobe toward the array is suppressed. When both reach the address in the same cycle, the left port wins.

A mode input selects how the busy flags come about. In master mode the block runs its own arbitration and drives the two active-low busy outputs with the result. In slave mode it does no arbitration. It takes the two busy levels from an external master, so that several devices can be ganged side by side for a wider word. It holds its own busy outputs inactive and uses the incoming busy levels only to gate writes. An incoming busy must read inactive for two consecutive cycles before a slave write may start. This gives the master's decision time to settle.

Arrival order is decided by the clock cycle in which a port's current access first appears. A port's access is new in a cycle when its enable has just risen, or when its address differs from the address it held in the previous cycle.

Top module: `contention_arb`

## Requirements
- R1: While the two enables are not both high, or the two addresses differ, both busy outputs are high (inactive).
- R2: In master mode, when the addresses match, the port whose access was already present in the previous cycle wins. The other port's busy output is low in the same cycle, and the winner's busy output is high.
- R3: In master mode, when both accesses are new in the same cycle on a matching address, the left port wins and r_busy_n is low. The same holds in the first cycle after reset.
- R4: A contention is raised by an address change that creates a match, with both enables already high. The port that did not move wins.
- R5: A contention is raised by an enable rising onto an address the other port already holds. The port that was already enabled wins.
- R6: Once a winner is chosen, both busy outputs hold their values for as long as the match lasts and neither port starts a new access. They return high in the cycle the winner's enable falls or the addresses diverge.
- R7: In master mode, l_wr_ok = l_en & l_wr & l_busy_n, and r_wr_ok follows the same rule on the right side. The ext_*_busy_n inputs have no effect in master mode.
- R8: In slave mode (master_sel low), both busy outputs stay high. A low ext_l_busy_n forces l_wr_ok low in that cycle, and a low ext_r_busy_n does the same for r_wr_ok.
- R9: In slave mode, a write passes (x_wr_ok = x_en & x_wr) only when the port's external busy is high in the current cycle and was also high in the previous cycle. After reset, the previous value counts as low.
- R10: While rst_n is low, both busy outputs are high, and no owner or arrival history survives into the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_sel | input | 1 | 1 = master (arbitrates), 0 = slave (consumes busy) |
| l_en | input | 1 | Left port enable, active high |
| l_addr | input | ADDR_W | Left port address |
| l_wr | input | 1 | Left port write strobe, active high |
| r_en | input | 1 | Right port enable, active high |
| r_addr | input | ADDR_W | Right port address |
| r_wr | input | 1 | Right port write strobe, active high |
| ext_l_busy_n | input | 1 | Left busy from the external master (slave mode) |
| ext_r_busy_n | input | 1 | Right busy from the external master (slave mode) |
| l_busy_n | output | 1 | Left busy, active low (master mode) |
| r_busy_n | output | 1 | Right busy, active low (master mode) |
| l_wr_ok | output | 1 | Gated left write enable toward the array |
| r_wr_ok | output | 1 | Gated right write enable toward the array |

## Verification
Contention detection and write gating can both fall in the same cycle: a losing port can raise its write strobe in the very cycle its busy goes low. The bench provokes this by asserting the write strobe together with the enable edge or address move that creates the match. The block must suppress that write at once, with no one-cycle leak. A second collision occurs when both ports move to a new common address in the same cycle while an owner is already recorded. Here the bench checks that the fresh tie rule replaces the stale owner. A behavioural model predicts every output each cycle, and the bench compares the design against it.

// File: rtl/contention_arb_pkg.sv
package contention_arb_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // Both enables high and the same address.
  function automatic logic same_slot(input logic a_en, input logic b_en,
                                     input logic [31:0] a_addr,
                                     input logic [31:0] b_addr);
    return a_en && b_en && (a_addr == b_addr);
  endfunction

  // Winner for a match given which sides are fresh this cycle.
  function automatic owner_e pick_owner(input logic match,
                                        input owner_e held,
                                        input logic fresh_l,
                                        input logic fresh_r);
    if (!match)                                   return OWN_NONE;
    if (held != OWN_NONE && !fresh_l && !fresh_r) return held;
    if (fresh_l && !fresh_r)                      return OWN_RIGHT;
    return OWN_LEFT;                              // left earlier, or tie
  endfunction

endpackage

// File: rtl/arb_arrival.sv
module arb_arrival #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              fresh
);
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en;
      addr_q <= addr;
    end
  end

  assign fresh = en && (!en_q || (addr != addr_q));
endmodule

// File: rtl/arb_core.sv
module arb_core
  import contention_arb_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              fresh_l,
  input  logic              fresh_r,
  output logic              match,
  output owner_e            owner_now
);
  localparam int PAD = 32 - ADDR_W;

  owner_e owner_q;

  assign match     = same_slot(l_en, r_en, {{PAD{1'b0}}, l_addr},
                               {{PAD{1'b0}}, r_addr});
  assign owner_now = pick_owner(match, owner_q, fresh_l, fresh_r);

  always_ff @(posedge clk) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= owner_now;
  end
endmodule

// File: rtl/arb_settle.sv
module arb_settle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_in_n,
  output logic clear_ok
);
  logic busy_q_n;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q_n <= 1'b0;
    else        busy_q_n <= busy_in_n;
  end

  assign clear_ok = busy_in_n && busy_q_n;
endmodule

// File: rtl/contention_arb.sv
module contention_arb
  import contention_arb_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_sel,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic              ext_l_busy_n,
  input  logic              ext_r_busy_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_wr_ok,
  output logic              r_wr_ok
);
  localparam int NPORT = 2;

  logic [NPORT-1:0]             en_v, wr_v, fresh_v, ext_v, clear_v;
  logic [NPORT-1:0][ADDR_W-1:0] addr_v;
  logic [NPORT-1:0]             busy_v_n;
  logic                         match_w;
  owner_e                       owner_w;

  assign en_v   = {r_en, l_en};
  assign wr_v   = {r_wr, l_wr};
  assign addr_v = {r_addr, l_addr};
  assign ext_v  = {ext_r_busy_n, ext_l_busy_n};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    arb_arrival #(.ADDR_W(ADDR_W)) arr_i (
      .clk(clk), .rst_n(rst_n), .en(en_v[p]), .addr(addr_v[p]),
      .fresh(fresh_v[p])
    );
    arb_settle set_i (
      .clk(clk), .rst_n(rst_n), .busy_in_n(ext_v[p]), .clear_ok(clear_v[p])
    );
  end

  arb_core #(.ADDR_W(ADDR_W)) core_i (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_addr(l_addr), .r_en(r_en), .r_addr(r_addr),
    .fresh_l(fresh_v[0]), .fresh_r(fresh_v[1]),
    .match(match_w), .owner_now(owner_w)
  );

  // Busy goes to the side that did not win; only a master drives it.
  assign busy_v_n[0] = !(master_sel && rst_n && owner_w == OWN_RIGHT);
  assign busy_v_n[1] = !(master_sel && rst_n && owner_w == OWN_LEFT);

  assign l_busy_n = busy_v_n[0];
  assign r_busy_n = busy_v_n[1];

  logic [NPORT-1:0] wr_ok_v;
  for (genvar p = 0; p < NPORT; p++) begin : g_gate
    assign wr_ok_v[p] = en_v[p] && wr_v[p] &&
                        (master_sel ? busy_v_n[p] : clear_v[p]);
  end

  assign l_wr_ok = wr_ok_v[0];
  assign r_wr_ok = wr_ok_v[1];
endmodule

// File: rtl/contention_arb_chk.sv
module contention_arb_chk (
  input logic clk,
  input logic rst_n,
  input logic master_sel,
  input logic l_en,
  input logic r_en,
  input logic l_wr,
  input logic r_wr,
  input logic ext_l_busy_n,
  input logic ext_r_busy_n,
  input logic l_busy_n,
  input logic r_busy_n,
  input logic l_wr_ok,
  input logic r_wr_ok,
  input logic match_w,
  input logic fresh_l,
  input logic fresh_r
);
  AST_NEVER_BOTH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n)); // R3

  AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_n || !r_busy_n) |-> match_w); // R1

  AST_MATCH_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && match_w) |-> (l_busy_n != r_busy_n)); // R2

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && $past(master_sel) && match_w && $past(match_w)
     && !fresh_l && !fresh_r) |-> ($stable(l_busy_n) && $stable(r_busy_n))); // R6

  AST_NO_LOSER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_n |-> !l_wr_ok) and (!r_busy_n |-> !r_wr_ok)); // R7

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !master_sel |-> (l_busy_n && r_busy_n)); // R8

  AST_SLAVE_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_sel && !$past(ext_l_busy_n)) |-> !l_wr_ok); // R9
endmodule

bind contention_arb contention_arb_chk chk_i (
  .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
  .l_en(l_en), .r_en(r_en), .l_wr(l_wr), .r_wr(r_wr),
  .ext_l_busy_n(ext_l_busy_n), .ext_r_busy_n(ext_r_busy_n),
  .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
  .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok),
  .match_w(match_w), .fresh_l(fresh_v[0]), .fresh_r(fresh_v[1])
);

// File: tb/contention_arb_tb_top.sv
module contention_arb_tb_top;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_sel = 1'b1;
  logic l_en = 0, r_en = 0, l_wr = 0, r_wr = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic ext_l_busy_n = 1, ext_r_busy_n = 1;
  logic l_busy_n, r_busy_n, l_wr_ok, r_wr_ok;

  int n_run = 0, n_fail = 0;

  // Reference state: 0 none, 1 left owns, 2 right owns.
  int m_own = 0;
  bit m_pl_en = 0, m_pr_en = 0, m_ql = 0, m_qr = 0;
  int m_pl_addr = 0, m_pr_addr = 0;

  always #5 clk = ~clk;

  contention_arb #(.ADDR_W(AW)) dut_i (.*);

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not end (got timeout, expected finish)");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic cmp(input string tag, input string nm, input bit got, input bit exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", tag, nm, got, exp);
    end
  endtask

  // Compare this cycle against the model, then advance one clock.
  task automatic step(input string tag);
    bit match, nl, nr, elb, erb, elw, erw;
    int cur;
    #1;
    match = l_en && r_en && (l_addr == r_addr);
    nl = l_en && (!m_pl_en || int'(l_addr) != m_pl_addr);
    nr = r_en && (!m_pr_en || int'(r_addr) != m_pr_addr);
    if (!match) cur = 0;
    else if (m_own != 0 && !nl && !nr) cur = m_own;
    else if (nl && !nr) cur = 2;
    else cur = 1;
    if (master_sel) begin
      elb = (cur != 2); erb = (cur != 1);
      elw = l_en && l_wr && elb; erw = r_en && r_wr && erb;
    end else begin
      elb = 1; erb = 1;
      elw = l_en && l_wr && ext_l_busy_n && m_ql;
      erw = r_en && r_wr && ext_r_busy_n && m_qr;
    end
    cmp(tag, "l_busy_n", l_busy_n, elb);
    cmp(tag, "r_busy_n", r_busy_n, erb);
    cmp(tag, "l_wr_ok", l_wr_ok, elw);
    cmp(tag, "r_wr_ok", r_wr_ok, erw);
    @(posedge clk);
    m_own = cur; m_pl_en = l_en; m_pr_en = r_en;
    m_pl_addr = int'(l_addr); m_pr_addr = int'(r_addr);
    m_ql = ext_l_busy_n; m_qr = ext_r_busy_n;
    @(negedge clk);
  endtask

  task automatic setp(input bit le, input int la, input bit lw,
                      input bit re, input int ra, input bit rw);
    l_en = le; l_addr = AW'(la); l_wr = lw;
    r_en = re; r_addr = AW'(ra); r_wr = rw;
  endtask

  initial begin
    @(negedge clk);
    setp(1, 3, 1, 1, 3, 1);
    #1;
    cmp("R10", "l_busy_n in reset", l_busy_n, 1);
    cmp("R10", "r_busy_n in reset", r_busy_n, 1);
    @(negedge clk); @(negedge clk);
    setp(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    rst_n = 1;
    // R1: no contention
    setp(1, 3, 1, 1, 5, 1); step("R1");
    setp(1, 3, 1, 0, 3, 1); step("R1");
    // R5: left enables onto address right already holds
    setp(0, 3, 0, 1, 3, 0); step("R1");
    setp(1, 3, 1, 1, 3, 1); step("R5");
    for (int i = 0; i < 3; i++) step("R6");
    ext_l_busy_n = 0; ext_r_busy_n = 0; step("R7");
    ext_l_busy_n = 1; ext_r_busy_n = 1;
    setp(1, 3, 1, 0, 3, 1); step("R6");
    // R4: right moves onto left's address
    setp(1, 7, 1, 1, 2, 1); step("R1");
    setp(1, 7, 1, 1, 7, 1); step("R4");
    step("R2");
    setp(1, 7, 1, 1, 8, 1); step("R6");
    // R3: simultaneous arrival
    setp(0, 0, 0, 0, 0, 0); step("R1");
    setp(1, 9, 1, 1, 9, 1); step("R3");
    step("R3");
    setp(1, 4, 1, 1, 4, 1); step("R3");
    setp(1, 4, 0, 1, 5, 0); step("R1");
    setp(1, 4, 1, 1, 4, 1); step("R2");
    step("R6");
    // Slave mode
    master_sel = 0;
    setp(1, 6, 1, 1, 6, 1); step("R8");
    ext_l_busy_n = 0; step("R8");
    ext_l_busy_n = 1; step("R9");
    step("R9");
    ext_r_busy_n = 0; step("R8");
    step("R8");
    ext_r_busy_n = 1; step("R9");
    step("R9");
    // Reset mid-contention clears history
    master_sel = 1;
    setp(1, 2, 1, 1, 2, 1); step("R3");
    setp(1, 2, 1, 1, 2, 1);
    rst_n = 0; @(negedge clk);
    m_own = 0; m_pl_en = 0; m_pr_en = 0; m_pl_addr = 0; m_pr_addr = 0;
    m_ql = 0; m_qr = 0;
    rst_n = 1;
    step("R10");
    master_sel = 0; step("R9");
    step("R9");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule